// File: doc/BRIEF.md
# Serial Transmit Engine with FIFO

This block takes bytes from a 16-entry first-in first-out buffer and shifts them out on a single serial line. The line is high when idle. Each frame has a low start bit, then the payload with the least significant bit first, then an optional parity bit, then one or two high stop bits. A strobe input, `tick_i`, runs at eight times the bit rate, and every bit lasts eight strobes. The block does not generate the bit rate, does not decode a bus and does not receive.

The format is chosen by a set of configuration inputs, and the block samples them once, at the moment a frame starts. The payload is 7 or 8 bits wide. Parity can be odd, even, forced to zero or forced to one. The software side reads three outputs: the number of free FIFO slots, a busy flag, and a sticky flag that records a dropped write. It controls the block with three inputs: a flush command, a break command that pulls the line low, and an optional clear-to-send handshake that holds back new frames.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd_o` is 1, `busy_o` is 0, `free_o` equals DEPTH (16) and `ovf_o` is 0.
- R2: A frame is one low start bit, then the payload with the least significant bit first, then the optional parity bit, then the stop bits (high). When `cfg_wide_i`=1 the payload has 8 bits. When it is 0 the payload has 7 bits and byte bit 7 is not sent.
- R3: When `cfg_par_en_i`=1, a parity bit follows the payload and `cfg_par_mode_i` sets its value: 0 makes the count of ones in payload plus parity odd, 1 makes it even, 2 sends 0, and 3 sends 1. When `cfg_par_en_i`=0 no parity bit is sent.
- R4: `cfg_two_stop_i`=1 sends two stop bits. `cfg_two_stop_i`=0 sends one.
- R5: Each bit lasts exactly 8 cycles in which `tick_i` is high. In cycles where `tick_i` is low, the line and the frame do not advance.
- R6: `free_o` equals DEPTH minus the number of stored bytes. An accepted write lowers it in the next cycle. Starting a frame removes the oldest entry in the same clock edge that raises `busy_o`.
- R7: A write when `free_o` is 0 is dropped and sets `ovf_o`. `ovf_o` stays set until a flush.
- R8: When `flush_i` is high, the FIFO is emptied (`free_o` = DEPTH) and `ovf_o` is cleared in the next cycle. A write in the same cycle as a flush is discarded. A frame that is already being sent runs to its end.
- R9: While `brk_i` is high, `txd_o` is 0 and no new frame starts. Once `brk_i` falls, a pending byte starts at the next clock edge.
- R10: While `flow_en_i` is 1 and `cts_ni` is 1 (not clear), no new frame starts. A frame already in progress finishes.
- R11: `busy_o` rises at the edge that starts the start bit and falls at the end of the last stop bit. A frame of N bits keeps `busy_o` high for 8·N tick cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Strobe at eight times the bit rate |
| wr_en_i | input | 1 | Push `wr_data_i` into the FIFO |
| wr_data_i | input | 8 | Byte to send |
| flush_i | input | 1 | Empty the FIFO and clear `ovf_o` |
| brk_i | input | 1 | Force the line low and hold back new frames |
| cfg_wide_i | input | 1 | 1: 8 payload bits, 0: 7 payload bits |
| cfg_two_stop_i | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_par_en_i | input | 1 | Append a parity bit |
| cfg_par_mode_i | input | 2 | 0 odd, 1 even, 2 zero, 3 one |
| flow_en_i | input | 1 | Enable the clear-to-send handshake |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| free_o | output | 5 | Free FIFO slots ($clog2(DEPTH+1) bits) |
| ovf_o | output | 1 | Sticky flag: a write was dropped |

## Verification
The assertions assume that every input holds a known value from the first edge after reset. They also assume that `brk_i` and `cts_ni` act only through the start decision, so a rising `busy_o` can be blamed on the values of the cycle before it. The stall property further assumes that `tick_i` is a plain level, sampled at each edge, with no hidden phase. The bench respects all of this: it changes every input only at falling clock edges, and it holds `tick_i` either steadily high or steadily low for whole stretches. Timing is therefore counted in whole cycles.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int BYTE_W        = 8;
    localparam int FRAME_MAX     = 12;
    localparam int LEN_W         = $clog2(FRAME_MAX + 1);
    localparam int TICKS_PER_BIT = 8;
    localparam int TICK_W        = $clog2(TICKS_PER_BIT);

    typedef enum logic [1:0] {
        PAR_ODD  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ZERO = 2'd2,
        PAR_ONE  = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic      wide;
        logic      two_stop;
        logic      par_en;
        par_mode_e par_mode;
    } frame_cfg_t;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [sertx_pkg::BYTE_W-1:0]    wr_data_i,
    input  logic                            pop_i,
    input  logic                            flush_i,
    output logic [sertx_pkg::BYTE_W-1:0]    rd_data_o,
    output logic                            empty_o,
    output logic [$clog2(DEPTH+1)-1:0]      free_o,
    output logic                            ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [sertx_pkg::BYTE_W-1:0] mem_q [DEPTH];
    logic full, push, pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == CW'(DEPTH));
        push = wr_en_i && !full && !flush_i;
        pop  = pop_i && (st_q.cnt != '0) && !flush_i;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (wr_en_i && full) st_d.ovf = 1'b1;
            if (push)            st_d.wp  = bump(st_q.wp);
            if (pop)             st_d.rp  = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push) mem_q[st_q.wp] <= wr_data_i;
    end

    assign rd_data_o = mem_q[st_q.rp];
    assign empty_o   = (st_q.cnt == '0);
    assign free_o    = CW'(DEPTH) - st_q.cnt;
    assign ovf_o     = st_q.ovf;
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [BYTE_W-1:0]    data_i,
    input  frame_cfg_t           cfg_i,
    output logic [FRAME_MAX-1:0] bits_o,
    output logic [LEN_W-1:0]     len_o
);
    logic [BYTE_W-1:0] payload;
    logic              par;

    always_comb begin
        payload = cfg_i.wide ? data_i : {1'b0, data_i[BYTE_W-2:0]};
        case (cfg_i.par_mode)
            PAR_ODD:  par = ~^payload;
            PAR_EVEN: par = ^payload;
            PAR_ZERO: par = 1'b0;
            default:  par = 1'b1;
        endcase
        bits_o    = '1;
        bits_o[0] = 1'b0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < BYTE_W - 1 || cfg_i.wide) bits_o[i+1] = payload[i];
        end
        if (cfg_i.par_en) begin
            if (cfg_i.wide) bits_o[BYTE_W+1] = par;
            else            bits_o[BYTE_W]   = par;
        end
        len_o = LEN_W'(BYTE_W + 1) + LEN_W'(cfg_i.wide)
              + LEN_W'(cfg_i.par_en) + LEN_W'(cfg_i.two_stop);
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 empty_i,
    input  logic [FRAME_MAX-1:0] frame_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic                 brk_i,
    input  logic                 flow_en_i,
    input  logic                 cts_ni,
    output logic                 pop_o,
    output logic                 txd_o,
    output logic                 busy_o
);
    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sh;
        logic [LEN_W-1:0]     left;
        logic [TICK_W-1:0]    tcnt;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      may_start;

    always_comb begin
        st_d      = st_q;
        pop_o     = 1'b0;
        may_start = !empty_i && !brk_i && (!flow_en_i || !cts_ni);
        if (!st_q.busy) begin
            if (may_start) begin
                st_d.busy = 1'b1;
                st_d.sh   = frame_i;
                st_d.left = len_i;
                st_d.tcnt = '0;
                pop_o     = 1'b1;
            end
        end else if (tick_i) begin
            if (st_q.tcnt == TICK_W'(TICKS_PER_BIT - 1)) begin
                st_d.tcnt = '0;
                st_d.sh   = {1'b1, st_q.sh[FRAME_MAX-1:1]};
                if (st_q.left == LEN_W'(1)) st_d.busy = 1'b0;
                else                        st_d.left = st_q.left - 1'b1;
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign txd_o  = brk_i ? 1'b0 : (st_q.busy ? st_q.sh[0] : 1'b1);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       tick_i,
    input  logic                       wr_en_i,
    input  logic [7:0]                 wr_data_i,
    input  logic                       flush_i,
    input  logic                       brk_i,
    input  logic                       cfg_wide_i,
    input  logic                       cfg_two_stop_i,
    input  logic                       cfg_par_en_i,
    input  logic [1:0]                 cfg_par_mode_i,
    input  logic                       flow_en_i,
    input  logic                       cts_ni,
    output logic                       txd_o,
    output logic                       busy_o,
    output logic [$clog2(DEPTH+1)-1:0] free_o,
    output logic                       ovf_o
);
    logic [BYTE_W-1:0]    head;
    logic                 empty, pop;
    logic [FRAME_MAX-1:0] frame;
    logic [LEN_W-1:0]     len;
    frame_cfg_t           cfg;

    assign cfg = '{wide:     cfg_wide_i,
                   two_stop: cfg_two_stop_i,
                   par_en:   cfg_par_en_i,
                   par_mode: par_mode_e'(cfg_par_mode_i)};

    sertx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .pop_i     (pop),
        .flush_i   (flush_i),
        .rd_data_o (head),
        .empty_o   (empty),
        .free_o    (free_o),
        .ovf_o     (ovf_o)
    );

    sertx_framer u_framer (
        .data_i (head),
        .cfg_i  (cfg),
        .bits_o (frame),
        .len_o  (len)
    );

    sertx_shifter u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .empty_i   (empty),
        .frame_i   (frame),
        .len_i     (len),
        .brk_i     (brk_i),
        .flow_en_i (flow_en_i),
        .cts_ni    (cts_ni),
        .pop_o     (pop),
        .txd_o     (txd_o),
        .busy_o    (busy_o)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       tick_i,
    input logic                       wr_en_i,
    input logic                       flush_i,
    input logic                       brk_i,
    input logic                       flow_en_i,
    input logic                       cts_ni,
    input logic                       txd_o,
    input logic                       busy_o,
    input logic [$clog2(DEPTH+1)-1:0] free_o,
    input logic                       ovf_o
);
    localparam int CW = $clog2(DEPTH + 1);

    p_free_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        free_o <= CW'(DEPTH));

    p_break_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_i |-> !txd_o);

    p_break_nostart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !$past(brk_i));

    p_idle_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !brk_i) |-> txd_o);

    p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !txd_o);

    p_flow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (!$past(flow_en_i) || !$past(cts_ni)));

    p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && free_o == '0 && !flush_i) |=> ovf_o);

    p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !flush_i) |=> ovf_o);

    p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (free_o == CW'(DEPTH) && !ovf_o));

    p_tick_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i && !brk_i) |=> (busy_o && ($stable(txd_o) || brk_i)));
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .flush_i   (flush_i),
    .brk_i     (brk_i),
    .flow_en_i (flow_en_i),
    .cts_ni    (cts_ni),
    .txd_o     (txd_o),
    .busy_o    (busy_o),
    .free_o    (free_o),
    .ovf_o     (ovf_o)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    localparam int DEPTH  = 16;
    localparam int MAXCYC = 100000;

    typedef struct packed {
        logic [7:0] data;
        logic       wide;
        logic       two;
        logic       pen;
        logic [1:0] mode;
        logic [3:0] len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hA5, 1'b1, 1'b0, 1'b0, 2'd0, 4'd10},
        '{8'h3C, 1'b1, 1'b0, 1'b1, 2'd0, 4'd11},
        '{8'h3C, 1'b1, 1'b0, 1'b1, 2'd1, 4'd11},
        '{8'h5A, 1'b0, 1'b1, 1'b1, 2'd2, 4'd11},
        '{8'hFF, 1'b0, 1'b0, 1'b1, 2'd3, 4'd10},
        '{8'h01, 1'b1, 1'b1, 1'b1, 2'd1, 4'd12},
        '{8'h80, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9},
        '{8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 4'd12}
    };

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
    logic       wr_en = 1'b0, flush = 1'b0, brk = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wide = 1'b1, two = 1'b0, pen = 1'b0;
    logic [1:0] mode = '0;
    logic       flow_en = 1'b0, cts_n = 1'b0;
    logic       txd, busy, ovf;
    logic [4:0] free;

    int checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    sertx_top #(.DEPTH(DEPTH)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .flush_i(flush), .brk_i(brk),
        .cfg_wide_i(wide), .cfg_two_stop_i(two), .cfg_par_en_i(pen),
        .cfg_par_mode_i(mode), .flow_en_i(flow_en), .cts_ni(cts_n),
        .txd_o(txd), .busy_o(busy), .free_o(free), .ovf_o(ovf)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > MAXCYC) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R5 watchdog actual %0d expected below %0d", cyc, MAXCYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void ref_frame(input logic [7:0] d, input logic w, input logic t,
                                      input logic p, input logic [1:0] m,
                                      output logic [11:0] f, output int n);
        int k = 1;
        int ones = 0;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < (w ? 8 : 7); i++) begin
            f[k] = d[i];
            ones += int'(d[i]);
            k++;
        end
        if (p) begin
            case (m)
                2'd0: f[k] = (ones % 2 == 0);
                2'd1: f[k] = (ones % 2 == 1);
                2'd2: f[k] = 1'b0;
                default: f[k] = 1'b1;
            endcase
            k++;
        end
        n = k + (t ? 2 : 1);
    endfunction

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(output logic [11:0] got, output int dur);
        int t = 0;
        int guard = 0;
        got = '1;
        while (!busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        while (busy && t < 2000) begin
            if (t % 8 == 4 && t / 8 < 12) got[t/8] = txd;
            t++;
            @(negedge clk);
        end
        dur = t;
    endtask

    initial begin
        logic [11:0] got, expf;
        int dur, n, t;

        repeat (3) @(negedge clk);
        chk("R1 txd in reset", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 free", int'(free), DEPTH);
        chk("R1 ovf", int'(ovf), 0);

        // table walk: R2 R3 R4 format, R5 R11 duration
        for (int v = 0; v < 8; v++) begin
            wide = VECS[v].wide; two = VECS[v].two;
            pen = VECS[v].pen;   mode = VECS[v].mode;
            wr(VECS[v].data);
            run_frame(got, dur);
            ref_frame(VECS[v].data, VECS[v].wide, VECS[v].two, VECS[v].pen,
                      VECS[v].mode, expf, n);
            chk($sformatf("R2 R3 R4 frame bits vec %0d", v), int'(got), int'(expf));
            chk($sformatf("R5 R11 busy cycles vec %0d", v), dur, 8 * int'(VECS[v].len));
            chk("R11 idle after frame", int'(txd), 1);
        end

        // overflow and flush: R6 R7 R8
        wide = 1'b1; two = 1'b0; pen = 1'b0; mode = 2'd0;
        flow_en = 1'b1; cts_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) wr(8'(i));
        chk("R6 free when full", int'(free), 0);
        chk("R10 no start while not clear", int'(busy), 0);
        chk("R7 ovf before overflow", int'(ovf), 0);
        wr(8'hEE);
        chk("R7 ovf set", int'(ovf), 1);
        chk("R7 free unchanged", int'(free), 0);
        repeat (5) @(negedge clk);
        chk("R7 ovf sticky", int'(ovf), 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R8 free after flush", int'(free), DEPTH);
        chk("R8 ovf cleared", int'(ovf), 0);
        flush = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        chk("R8 write with flush dropped", int'(free), DEPTH);

        // flow control and flush during a frame: R6 R8 R10
        wr(8'h11); wr(8'h22); wr(8'h33);
        chk("R6 free after three writes", int'(free), DEPTH - 3);
        repeat (20) @(negedge clk);
        chk("R10 held off", int'(busy), 0);
        cts_n = 1'b0;
        @(negedge clk);
        chk("R10 start once clear", int'(busy), 1);
        chk("R6 pop at start", int'(free), DEPTH - 2);
        cts_n = 1'b1;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        t = 2;
        chk("R8 flush mid frame", int'(free), DEPTH);
        @(negedge clk);
        while (busy && t < 500) begin
            t++;
            @(negedge clk);
        end
        chk("R8 R10 frame completes", t, 80);
        cts_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 nothing left to send", int'(busy), 0);

        // break: R9
        flow_en = 1'b0;
        brk = 1'b1;
        wr(8'h55);
        chk("R9 line low", int'(txd), 0);
        repeat (20) @(negedge clk);
        chk("R9 no start in break", int'(busy), 0);
        chk("R9 line held low", int'(txd), 0);
        chk("R9 byte kept", int'(free), DEPTH - 1);
        brk = 1'b0;
        @(negedge clk);
        chk("R9 start after release", int'(busy), 1);
        run_frame(got, dur);
        ref_frame(8'h55, 1'b1, 1'b0, 1'b0, 2'd0, expf, n);
        chk("R9 frame after break", int'(got), int'(expf));

        // tick stall: R5
        tick = 1'b0;
        wr(8'hC3);
        @(negedge clk);
        chk("R5 started without ticks", int'(busy), 1);
        repeat (40) @(negedge clk);
        chk("R5 busy held", int'(busy), 1);
        chk("R5 start bit held", int'(txd), 0);
        tick = 1'b1;
        run_frame(got, dur);
        ref_frame(8'hC3, 1'b1, 1'b0, 1'b0, 2'd0, expf, n);
        chk("R5 frame after stall", int'(got), int'(expf));
        chk("R5 R11 duration after stall", dur, 80);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule